// File: doc/BRIEF.md
# SDRAM Bank State and Burst Interruption Tracker

This block sits beside the command scheduler of an SDRAM controller. It watches every command placed on the command bus and keeps a registered state for each bank: idle, row open, bursting (read or write, with or without automatic precharge), waiting out write recovery, or precharging. The scheduler uses these states to choose its next command.

The device has one shared data bus. A READ or WRITE to one bank therefore cuts short any burst still running in another bank. The tracker works out what happens to the bank that is cut off. A plain burst simply stops. A read with automatic precharge starts precharging at once. A write with automatic precharge first counts write recovery from the cycle of the interrupting command, and only then precharges.

Any command that breaks the bank rules is flagged with a one-cycle pulse and leaves the state unchanged. For read-to-write turnaround, the scheduler announces a planned WRITE three cycles ahead. The block then raises a DQM request in the right cycles so that read data still arriving on the bus is masked.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bank state reads 0 (idle), and `illegal_o` and `dqm_o` are 0.
- R2: ACTIVE (cmd 1) to an idle bank shows state 1 (row open) one cycle later. ACTIVE to a bank that is not idle is flagged and changes nothing.
- R3: READ (cmd 2) or WRITE (cmd 3) to an open bank shows state 2, 3, 4 or 5 (read, read+AP, write, write+AP) for BL cycles. After that, a plain burst returns to 1. Read+AP goes to 7 (precharge) for tRP cycles and then to 0. Write+AP goes to 6 (recovery) for tWR cycles, then to 7 for tRP cycles, then to 0.
- R4: READ or WRITE to a bank that is idle, precharging, recovering or in an auto-precharge burst is flagged and has no effect.
- R5: A legal READ or WRITE to bank m ends a plain burst on bank n, which shows 1 from the next cycle. At most one bank is ever bursting.
- R6: When a read+AP burst on bank n is interrupted, bank n shows 7 from the cycle after the interrupting command and 0 after tRP cycles.
- R7: When a write+AP burst on bank n is interrupted, bank n shows 6 for tWR cycles counted from the interrupting command, then 7 for tRP cycles, then 0.
- R8: ACTIVE to a bank that is still precharging is flagged. The bank accepts ACTIVE once it shows 0.
- R9: BURST TERMINATE (cmd 5) is legal only on the bank running a plain burst, and returns that bank to 1. Sent to any other bank, or to a burst with auto precharge, it is flagged and has no effect.
- R10: AUTO REFRESH (cmd 6), LOAD MODE (cmd 7) and SELF REFRESH (cmd 8) are legal only when every bank is idle.
- R11: PRECHARGE (cmd 4) to a bank showing 1, 2 or 4 moves it to 7 for tRP cycles. To a bank showing 0 or 7 it is legal and has no effect. To a bank showing 3, 5 or 6 it is flagged.
- R12: `illegal_o` is high for exactly the cycle after a flagged command. Codes 9 to 15 are always flagged. NOP (cmd 0) is never flagged.
- R13: Suppose `wr_ahead_i` is high in cycle t, a WRITE follows in cycle t+3, and read data is still due on the bus. Then `dqm_o` is high in cycle t+2. If that read has auto precharge, `dqm_o` is also high in cycle t+1. With no read data due, `dqm_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SDRAM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 4 | Command code for this cycle (0 = NOP) |
| bank_i | input | log2(NBANK) | Target bank of the command |
| auto_pre_i | input | 1 | READ/WRITE carries auto precharge |
| wr_ahead_i | input | 1 | A WRITE is planned three cycles from now |
| bank_state_o | output | 3*NBANK | Per-bank state, 3 bits per bank, bank 0 in the lowest bits |
| illegal_o | output | 1 | One-cycle flag for a rejected command |
| dqm_o | output | 1 | Data mask request for read-to-write turnaround |

## Verification
A wrong bank state appears on `bank_state_o` one cycle after the command or timer expiry that caused it. The same error also reaches `illegal_o` at the next command that the wrong state would wrongly accept or reject. A miscounted recovery or precharge timer shifts the cycle in which the state returns to idle by at least one cycle, so sweeps that sample every cycle from the command up to idle pin it down exactly. A DQM fault shows within three cycles of the lookahead strobe, as a mask that comes one cycle early, one cycle late or not at all.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_ACT  = 3'd1,
    BS_RD   = 3'd2,
    BS_RDA  = 3'd3,
    BS_WR   = 3'd4,
    BS_WRA  = 3'd5,
    BS_WREC = 3'd6,
    BS_PRE  = 3'd7
  } bank_st_e;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_WR   = 4'd3,
    C_PRE  = 4'd4,
    C_BST  = 4'd5,
    C_REF  = 4'd6,
    C_LMR  = 4'd7,
    C_SREF = 4'd8
  } cmd_e;

  function automatic logic is_burst(bank_st_e s);
    return (s == BS_RD) || (s == BS_RDA) || (s == BS_WR) || (s == BS_WRA);
  endfunction

endpackage

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
  import sdram_trk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  cmd_e                  cmd_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  bank_st_e [NBANK-1:0]  st_i,
  output logic                  legal_o
);

  logic     all_idle;
  bank_st_e tgt;

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NBANK; i++) begin
      if (st_i[i] != BS_IDLE) all_idle = 1'b0;
    end
  end

  assign tgt = st_i[bank_i];

  always_comb begin
    unique case (cmd_i)
      C_NOP:  legal_o = 1'b1;
      C_ACT:  legal_o = (tgt == BS_IDLE);
      C_RD,
      C_WR:   legal_o = (tgt == BS_ACT) || (tgt == BS_RD) || (tgt == BS_WR);
      C_PRE:  legal_o = (tgt == BS_IDLE) || (tgt == BS_ACT) || (tgt == BS_RD) ||
                        (tgt == BS_WR) || (tgt == BS_PRE);
      C_BST:  legal_o = (tgt == BS_RD) || (tgt == BS_WR);
      C_REF,
      C_LMR,
      C_SREF: legal_o = all_idle;
      default: legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int BL  = 4,
  parameter int TWR = 2,
  parameter int TRP = 3,
  parameter int CW  = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     legal_i,
  input  cmd_e     cmd_i,
  input  logic     sel_i,
  input  logic     ap_i,
  output bank_st_e st_o
);

  bank_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    // timer expiry
    if (cnt_q == CW'(1)) begin
      unique case (st_q)
        BS_RD, BS_WR: st_d = BS_ACT;
        BS_RDA:  begin st_d = BS_PRE;  cnt_d = CW'(TRP); end
        BS_WRA:  begin st_d = BS_WREC; cnt_d = CW'(TWR); end
        BS_WREC: begin st_d = BS_PRE;  cnt_d = CW'(TRP); end
        BS_PRE:  st_d = BS_IDLE;
        default: ;
      endcase
    end
    if (legal_i && sel_i) begin
      unique case (cmd_i)
        C_ACT: st_d = BS_ACT;
        C_RD:  begin st_d = ap_i ? BS_RDA : BS_RD; cnt_d = CW'(BL); end
        C_WR:  begin st_d = ap_i ? BS_WRA : BS_WR; cnt_d = CW'(BL); end
        C_PRE: begin
          if (st_q == BS_ACT || st_q == BS_RD || st_q == BS_WR) begin
            st_d  = BS_PRE;
            cnt_d = CW'(TRP);
          end
        end
        C_BST: begin st_d = BS_ACT; cnt_d = '0; end
        default: ;
      endcase
    end else if (legal_i && (cmd_i == C_RD || cmd_i == C_WR)) begin
      // another bank takes the data bus
      unique case (st_q)
        BS_RD, BS_WR: begin st_d = BS_ACT;  cnt_d = '0; end
        BS_RDA:       begin st_d = BS_PRE;  cnt_d = CW'(TRP); end
        BS_WRA:       begin st_d = BS_WREC; cnt_d = CW'(TWR); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;

  a_r2_idle_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_IDLE) |=> (st_q inside {BS_IDLE, BS_ACT}));

  a_r8_pre_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_PRE) |=> (st_q inside {BS_PRE, BS_IDLE}));

  a_r7_wrec_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_WREC) |=> (st_q inside {BS_WREC, BS_PRE}));

  a_r6_rda_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_RDA) |=> (st_q inside {BS_RDA, BS_PRE}));

endmodule

// File: rtl/sdram_dqm_ctrl.sv
module sdram_dqm_ctrl #(
  parameter int CL = 2,
  parameter int BL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_go_i,
  input  logic wr_go_i,
  input  logic ap_i,
  input  logic ahead_i,
  output logic dqm_o
);

  localparam int RW = $clog2(CL + BL + 1);

  logic [RW-1:0] live_q;
  logic          ap_q, s1_q, dqm_q;
  logic          live_now, ap_now;

  assign live_now = rd_go_i || (live_q != '0);
  assign ap_now   = rd_go_i ? ap_i : ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      ap_q   <= 1'b0;
      s1_q   <= 1'b0;
      dqm_q  <= 1'b0;
    end else begin
      if (rd_go_i) begin
        live_q <= RW'(CL + BL);
        ap_q   <= ap_i;
      end else if (wr_go_i) begin
        live_q <= '0;
      end else if (live_q != '0) begin
        live_q <= live_q - 1'b1;
      end
      s1_q  <= ahead_i && live_now;
      // auto-precharge read: mask two cycles ahead of the write, else one
      dqm_q <= (ahead_i && live_now && ap_now) || s1_q;
    end
  end

  assign dqm_o = dqm_q;

  a_r13_dqm_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_q |-> ($past(ahead_i) || $past(ahead_i, 2)));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int CL    = 2,
  parameter int BL    = 4,
  parameter int TWR   = 2,
  parameter int TRP   = 3,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3:0]            cmd_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic                  auto_pre_i,
  input  logic                  wr_ahead_i,
  output logic [3*NBANK-1:0]    bank_state_o,
  output logic                  illegal_o,
  output logic                  dqm_o
);

  localparam int TMAX = (BL > TWR) ? ((BL > TRP) ? BL : TRP) : ((TWR > TRP) ? TWR : TRP);
  localparam int CW   = $clog2(TMAX + 1);

  cmd_e                 cmd;
  bank_st_e [NBANK-1:0] st;
  logic [NBANK-1:0]     bursting;
  logic                 legal, illegal_q;

  assign cmd = cmd_e'(cmd_i);

  sdram_cmd_check #(.NBANK(NBANK), .BANK_W(BANK_W)) u_check (
    .cmd_i   (cmd),
    .bank_i  (bank_i),
    .st_i    (st),
    .legal_o (legal)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdram_bank_fsm #(.BL(BL), .TWR(TWR), .TRP(TRP), .CW(CW)) u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .legal_i (legal),
      .cmd_i   (cmd),
      .sel_i   (bank_i == BANK_W'(g)),
      .ap_i    (auto_pre_i),
      .st_o    (st[g])
    );
    assign bursting[g]         = is_burst(st[g]);
    assign bank_state_o[3*g +: 3] = st[g];
  end

  sdram_dqm_ctrl #(.CL(CL), .BL(BL)) u_dqm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_go_i (legal && cmd == C_RD),
    .wr_go_i (legal && cmd == C_WR),
    .ap_i    (auto_pre_i),
    .ahead_i (wr_ahead_i),
    .dqm_o   (dqm_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= !legal;
  end

  assign illegal_o = illegal_q;

  a_r5_one_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bursting));

  a_r12_nop_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> ($past(cmd_i) != 4'd0));

endmodule

// File: tb/sdram_bank_tracker_test.sv
module sdram_bank_tracker_test;
  localparam int NB = 4, CL = 2, BL = 4, TWR = 2, TRP = 3;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, BST = 5, REF = 6, LMR = 7, SREF = 8;
  localparam int S_IDLE = 0, S_ACT = 1, S_RD = 2, S_RDA = 3, S_WR = 4, S_WRA = 5, S_WREC = 6, S_PRE = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] cmd = '0;
  logic [1:0] bank = '0;
  logic ap = 1'b0, ahead = 1'b0;
  logic [3*NB-1:0] st;
  logic ill, dqm;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_bank_tracker #(.NBANK(NB), .CL(CL), .BL(BL), .TWR(TWR), .TRP(TRP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .bank_i(bank), .auto_pre_i(ap),
    .wr_ahead_i(ahead), .bank_state_o(st), .illegal_o(ill), .dqm_o(dqm));

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sb(int b);
    return int'(st[b*3 +: 3]);
  endfunction

  task automatic cyc(int c, int b, bit a);
    cmd = 4'(c); bank = 2'(b); ap = a;
    @(negedge clk);
    cmd = '0; ap = 1'b0;
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) cyc(NOP, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", "state in reset", int'(st), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "state after reset", int'(st), 0);
    chk("R1", "illegal after reset", int'(ill), 0);
    chk("R1", "dqm after reset", int'(dqm), 0);

    // R2 activate every bank, then repeat
    for (int b = 0; b < NB; b++) begin
      cyc(ACT, b, 0);
      chk("R2", "act state", sb(b), S_ACT);
      chk("R2", "act legal", int'(ill), 0);
      cyc(ACT, b, 0);
      chk("R2", "re-act flagged", int'(ill), 1);
      chk("R2", "re-act no change", sb(b), S_ACT);
    end

    // R10 refresh/mode/self refresh rejected with open rows
    cyc(REF, 0, 0);  chk("R10", "ref busy", int'(ill), 1);
    cyc(LMR, 0, 0);  chk("R10", "lmr busy", int'(ill), 1);
    cyc(SREF, 0, 0); chk("R10", "sref busy", int'(ill), 1);

    // R3 plain read on bank 0
    cyc(RD, 0, 0);
    for (int k = 0; k <= BL + 1; k++) begin
      if (k > 0) cyc(NOP, 0, 0);
      chk("R3", "plain read", sb(0), (k < BL) ? S_RD : S_ACT);
    end

    // R3 write with AP on bank 1
    cyc(WR, 1, 1);
    for (int k = 0; k <= BL + TWR + TRP + 1; k++) begin
      if (k > 0) cyc(NOP, 0, 0);
      chk("R3", "write ap", sb(1),
          (k < BL) ? S_WRA : (k < BL + TWR) ? S_WREC : (k < BL + TWR + TRP) ? S_PRE : S_IDLE);
    end
    cyc(ACT, 1, 0);
    chk("R3", "reopen after ap", sb(1), S_ACT);

    // R5 plain interrupts
    cyc(RD, 0, 0);
    cyc(RD, 2, 0);
    chk("R5", "rd cut by rd", sb(0), S_ACT);
    chk("R5", "new rd", sb(2), S_RD);
    cyc(WR, 0, 0);
    chk("R5", "rd cut by wr", sb(2), S_ACT);
    chk("R5", "new wr", sb(0), S_WR);
    nops(BL);
    chk("R5", "wr done", sb(0), S_ACT);

    // R6 read with AP interrupted; R8 activate during precharge
    cyc(RD, 0, 1);
    chk("R6", "rda start", sb(0), S_RDA);
    cyc(WR, 2, 0);
    chk("R6", "rda cut -> pre", sb(0), S_PRE);
    cyc(ACT, 0, 0);
    chk("R8", "act in pre flagged", int'(ill), 1);
    chk("R8", "act in pre no change", sb(0), S_PRE);
    for (int k = 2; k <= TRP; k++) begin
      cyc(NOP, 0, 0);
      chk("R6", "pre countdown", sb(0), (k < TRP) ? S_PRE : S_IDLE);
    end
    cyc(ACT, 0, 0);
    chk("R8", "act after idle", sb(0), S_ACT);
    chk("R8", "act after idle legal", int'(ill), 0);
    nops(2);
    chk("R5", "bank2 wr done", sb(2), S_ACT);

    // R7 write with AP interrupted
    cyc(WR, 2, 1);
    cyc(RD, 0, 0);
    for (int k = 0; k <= TWR + TRP; k++) begin
      if (k > 0) cyc(NOP, 0, 0);
      chk("R7", "wra cut", sb(2),
          (k < TWR) ? S_WREC : (k < TWR + TRP) ? S_PRE : S_IDLE);
    end
    cyc(ACT, 2, 0);
    nops(BL);
    chk("R7", "bank0 read done", sb(0), S_ACT);

    // R9 burst terminate
    cyc(RD, 0, 0);
    cyc(BST, 1, 0);
    chk("R9", "bst other bank flagged", int'(ill), 1);
    chk("R9", "bst other bank no effect", sb(0), S_RD);
    cyc(BST, 0, 0);
    chk("R9", "bst own bank legal", int'(ill), 0);
    chk("R9", "bst ends burst", sb(0), S_ACT);
    cyc(RD, 0, 1);
    cyc(BST, 0, 0);
    chk("R9", "bst on ap flagged", int'(ill), 1);
    chk("R9", "bst on ap no effect", sb(0), S_RDA);
    nops(BL + TRP);
    chk("R6", "rda idle", sb(0), S_IDLE);
    cyc(ACT, 0, 0);

    // R11 precharge
    cyc(PRE, 3, 0);
    chk("R11", "pre open bank", sb(3), S_PRE);
    cyc(PRE, 3, 0);
    chk("R11", "pre on pre legal", int'(ill), 0);
    chk("R11", "pre on pre", sb(3), S_PRE);
    cyc(PRE, 1, 0);
    chk("R11", "pre on open b1", sb(1), S_PRE);
    nops(TRP);
    chk("R11", "pre done", sb(3), S_IDLE);
    cyc(PRE, 1, 0);
    chk("R11", "pre on idle legal", int'(ill), 0);
    chk("R11", "pre on idle", sb(1), S_IDLE);
    cyc(WR, 0, 1);
    cyc(PRE, 0, 0);
    chk("R11", "pre on wra flagged", int'(ill), 1);
    chk("R11", "pre on wra no effect", sb(0), S_WRA);
    nops(BL + TWR + TRP);
    chk("R11", "wra idle", sb(0), S_IDLE);

    // R4 access to closed banks
    cyc(RD, 3, 0);
    chk("R4", "rd idle flagged", int'(ill), 1);
    chk("R4", "rd idle no effect", sb(3), S_IDLE);
    cyc(WR, 1, 0);
    chk("R4", "wr idle flagged", int'(ill), 1);
    chk("R4", "wr idle no effect", sb(1), S_IDLE);

    // R10 all idle
    cyc(REF, 0, 0);
    chk("R10", "ref with b2 open", int'(ill), 1);
    cyc(PRE, 2, 0);
    nops(TRP);
    chk("R10", "all idle", int'(st), 0);
    cyc(REF, 0, 0);  chk("R10", "ref idle", int'(ill), 0);
    cyc(LMR, 0, 0);  chk("R10", "lmr idle", int'(ill), 0);
    cyc(SREF, 0, 0); chk("R10", "sref idle", int'(ill), 0);

    // R12 reserved codes and pulse width
    for (int c = 9; c < 16; c++) begin
      cyc(c, 0, 0);
      chk("R12", "reserved code", int'(ill), 1);
      cyc(NOP, 0, 0);
      chk("R12", "pulse one cycle", int'(ill), 0);
    end
    chk("R12", "reserved no effect", int'(st), 0);

    // R13 dqm lead
    cyc(ACT, 0, 0);
    cyc(ACT, 1, 0);
    cyc(RD, 0, 1);
    ahead = 1'b1; cyc(NOP, 0, 0); ahead = 1'b0;
    chk("R13", "ap read W-2", int'(dqm), 1);
    cyc(NOP, 0, 0);
    chk("R13", "ap read W-1", int'(dqm), 1);
    cyc(NOP, 0, 0);
    chk("R13", "ap read at W", int'(dqm), 0);
    cyc(WR, 1, 0);
    chk("R13", "ap read after W", int'(dqm), 0);
    nops(BL + 1);
    cyc(RD, 1, 0);
    ahead = 1'b1; cyc(NOP, 0, 0); ahead = 1'b0;
    chk("R13", "plain read W-2", int'(dqm), 0);
    cyc(NOP, 0, 0);
    chk("R13", "plain read W-1", int'(dqm), 1);
    cyc(NOP, 0, 0);
    chk("R13", "plain read at W", int'(dqm), 0);
    cyc(WR, 1, 0);
    nops(CL + BL + 2);
    ahead = 1'b1; cyc(NOP, 0, 0); ahead = 1'b0;
    chk("R13", "no read W-2", int'(dqm), 0);
    cyc(NOP, 0, 0);
    chk("R13", "no read W-1", int'(dqm), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule